// File: doc/BRIEF.md
# Dual-Mode Conversion Word Serial Port

This block sends a 24-bit conversion result out of a converter on a single data line, most significant bit first. A `word_valid_i` pulse hands in each result, and an active-low ready flag tells the host that a word is waiting. The result is held in a word register. An output bit index picks which bit drives `sdo_o`, so the stored word itself is never shifted.

A static mode input picks how the port is clocked. In master mode the port makes its own serial clock. Each bit takes one MCLK cycle low and one MCLK cycle high, which gives MCLK/2. The burst starts a fixed number of cycles after a word is ready while chip select is low. In slave mode the port follows an external serial clock, which may run continuously or with gaps. That clock and chip select are synchronized to MCLK and edge-detected, so the block has one clock domain. The external clock must therefore stay well below MCLK/2.

A polarity select is captured with each word and chooses the coding: two's complement, or offset binary made by inverting the MSB. A word that arrives during a read waits in a shadow register and takes over once the read ends. The output enables for data and clock are asserted only while the synchronized chip select is low.

Top module: `conv_sport`

## Requirements
- R1: In master mode, `sclk_o` is high for exactly one MCLK cycle and low for exactly one MCLK cycle per bit, with 24 high pulses per word, and it stays low when no read is in progress.
- R2: In master mode, the first `sclk_o` rise of a word comes no earlier than START_DLY (default 8) MCLK cycles after a ready word and a low synchronized chip select first coincide.
- R3: In master mode, `sdo_o` carries the word MSB first, and each bit is stable while `sclk_o` is high.
- R4: In slave mode, `sdo_o` carries the word MSB first. Each bit is valid before every rising edge of `sclk_i`. The bit advances only after a falling edge of `sclk_i` that follows a rising edge, and gaps of any length in `sclk_i` are allowed.
- R5: `rdy_no` goes low one cycle after a `word_valid_i` pulse. It returns high only after the last of the 24 bits has been clocked: after the 24th high phase in master mode, or after the falling edge that follows the 24th rising edge in slave mode.
- R6: `sdo_oe_o` is 1 only while the two-stage-synchronized `cs_ni` is low. `sclk_oe_o` follows the same rule in master mode and is always 0 in slave mode. All enables are 0 out of reset.
- R7: With `bipolar_i`=1 the word is sent unchanged (two's complement: 7FFFFF is positive full scale, 800000 is negative full scale). With `bipolar_i`=0 its MSB is inverted (offset binary: 800000 is sent as 000000 and 7FFFFF as FFFFFF). `bipolar_i` is sampled with `word_valid_i`.
- R8: A word that arrives while a read is in progress does not disturb the word being sent. It is presented right after that read ends, and `rdy_no` stays low in between.
- R9: If chip select rises during a read, the clock stops and the outputs are disabled while `rdy_no` stays low. The next chip-select fall restarts the same word from its MSB.
- R10: A word that arrives while the pending word has not started to be read replaces the pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (MCLK) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_slave_i | input | 1 | Static mode: 1 = slave (external clock), 0 = master |
| bipolar_i | input | 1 | Coding select, sampled with word_valid_i |
| word_valid_i | input | 1 | One-cycle pulse: a new conversion word is on word_i |
| word_i | input | 24 | Conversion result in two's complement |
| cs_ni | input | 1 | Active-low chip select, asynchronous |
| sclk_i | input | 1 | External serial clock (slave mode), asynchronous |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| sclk_oe_o | output | 1 | Output enable for the serial clock pad |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data pad |
| rdy_no | output | 1 | Active-low ready: an unread word is held |

## Verification
If the bit index is stuck or skips a value, the captured word comes out rotated or repeated, and every read checked against the expected code shows it. If the master phase machine is wrong, high pulses wider than one cycle or missing rises appear within the first two bits, or the first rise comes too early. If the load and shadow logic is wrong, the back-to-back read shows it within one word: the second word is lost, the first is corrupted, or `rdy_no` rises between the two. An unsynchronized or mis-gated chip select shows up as enables that change in the wrong cycle around a chip-select edge.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_WAIT = 2'd1,
    M_LOW  = 2'd2,
    M_HIGH = 2'd3
  } mst_state_e;
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int          N       = 2,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sport_mst_seq.sv
module sport_mst_seq #(
  parameter int W         = 24,
  parameter int START_DLY = 8,
  localparam int IW = $clog2(W),
  localparam int DW = $clog2(START_DLY + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic          sclk_o,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  import sport_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(W - 1);

  mst_state_e    st_q;
  logic [DW-1:0] dcnt_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_IDLE;
      dcnt_q <= '0;
      idx_q  <= '0;
    end else if (!go_i) begin
      st_q   <= M_IDLE;
      dcnt_q <= '0;
      idx_q  <= '0;
    end else begin
      unique case (st_q)
        M_IDLE: begin
          st_q   <= M_WAIT;
          dcnt_q <= '0;
          idx_q  <= '0;
        end
        M_WAIT: begin
          if (dcnt_q == DW'(START_DLY - 1)) st_q <= M_LOW;
          else dcnt_q <= dcnt_q + 1'b1;
        end
        M_LOW:  st_q <= M_HIGH;
        M_HIGH: begin
          if (idx_q == LAST) begin
            st_q  <= M_IDLE;
            idx_q <= '0;
          end else begin
            st_q  <= M_LOW;
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign sclk_o = (st_q == M_HIGH);
  assign busy_o = (st_q != M_IDLE);
  assign idx_o  = idx_q;
  assign done_o = go_i && (st_q == M_HIGH) && (idx_q == LAST);

  AST_SCLK_ONE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |=> !sclk_o); // R1
  AST_SCLK_STOPS_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_i |=> !sclk_o); // R9
  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o <= LAST); // R3
endmodule

// File: rtl/sport_slv_seq.sv
module sport_slv_seq #(
  parameter int W = 24,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          sclk_s_i,
  input  logic          armed_i,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  logic          sclk_q, seen_q;
  logic [IW-1:0] idx_q;
  logic          rise, fall;

  assign rise = sclk_s_i && !sclk_q;
  assign fall = !sclk_s_i && sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      seen_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      if (cs_s_i || !armed_i) begin
        seen_q <= 1'b0;
        idx_q  <= '0;
      end else if (rise) begin
        seen_q <= 1'b1;
      end else if (fall && seen_q) begin
        seen_q <= 1'b0;
        idx_q  <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign idx_o  = idx_q;
  assign done_o = !cs_s_i && armed_i && fall && seen_q && (idx_q == LAST);

  AST_IDX_MOVES_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s_i && armed_i && !fall) |=> $stable(idx_o)); // R4
  AST_SLV_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o <= LAST); // R4
endmodule

// File: rtl/conv_sport.sv
module conv_sport #(
  parameter int W           = 24,
  parameter int START_DLY   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_slave_i,
  input  logic         bipolar_i,
  input  logic         word_valid_i,
  input  logic [W-1:0] word_i,
  input  logic         cs_ni,
  input  logic         sclk_i,
  output logic         sclk_o,
  output logic         sclk_oe_o,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic         rdy_no
);
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  logic [1:0]    sync_q;
  logic          cs_s, sclk_s;
  logic [W-1:0]  word_q, shadow_q, coded;
  logic          loaded_q, shadow_v_q;
  logic          m_go, m_sclk, m_busy, m_done, s_done, done, busy;
  logic [IW-1:0] m_idx, s_idx, idx;

  sport_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i}),
    .q_o   (sync_q)
  );
  assign cs_s   = sync_q[1];
  assign sclk_s = sync_q[0];

  assign m_go = loaded_q && !cs_s && !mode_slave_i;

  sport_mst_seq #(.W(W), .START_DLY(START_DLY)) u_mst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (m_go),
    .sclk_o(m_sclk),
    .busy_o(m_busy),
    .idx_o (m_idx),
    .done_o(m_done)
  );

  sport_slv_seq #(.W(W)) u_slv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_s_i  (cs_s),
    .sclk_s_i(sclk_s),
    .armed_i (loaded_q && mode_slave_i),
    .idx_o   (s_idx),
    .done_o  (s_done)
  );

  assign idx  = mode_slave_i ? s_idx : m_idx;
  assign done = mode_slave_i ? s_done : m_done;
  assign busy = mode_slave_i ? (!cs_s && loaded_q) : m_busy;

  // unipolar: offset binary by MSB inversion
  assign coded = word_i ^ {!bipolar_i, {(W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q     <= '0;
      shadow_q   <= '0;
      loaded_q   <= 1'b0;
      shadow_v_q <= 1'b0;
    end else if (done) begin
      if (word_valid_i) begin
        word_q     <= coded;
        shadow_v_q <= 1'b0;
      end else if (shadow_v_q) begin
        word_q     <= shadow_q;
        shadow_v_q <= 1'b0;
      end else begin
        loaded_q <= 1'b0;
      end
    end else if (word_valid_i) begin
      if (loaded_q && busy) begin
        shadow_q   <= coded;
        shadow_v_q <= 1'b1;
      end else begin
        word_q   <= coded;
        loaded_q <= 1'b1;
      end
    end
  end

  assign sdo_o     = loaded_q && word_q[LAST - idx];
  assign sdo_oe_o  = !cs_s;
  assign sclk_oe_o = !cs_s && !mode_slave_i;
  assign sclk_o    = !mode_slave_i && m_sclk;
  assign rdy_no    = !loaded_q;

  AST_SHADOW_NEEDS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_v_q |-> loaded_q); // R8
  AST_WORD_FROZEN_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> $stable(word_q)); // R8
  AST_RDY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !word_valid_i && !shadow_v_q) |=> rdy_no); // R5
  AST_DONE_NEEDS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !rdy_no); // R5
endmodule

// File: tb/conv_sport_bench.sv
module conv_sport_bench;
  localparam int W = 24;
  localparam int START_DLY = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_slave = 1'b0, bipolar = 1'b1, word_valid = 1'b0;
  logic [W-1:0] word = '0;
  logic cs_n = 1'b1, sclk_in = 1'b0;
  logic sclk_o, sclk_oe, sdo, sdo_oe, rdy_n;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  conv_sport #(.W(W), .START_DLY(START_DLY)) u_conv_sport (
    .clk_i(clk), .rst_ni(rst_ni), .mode_slave_i(mode_slave), .bipolar_i(bipolar),
    .word_valid_i(word_valid), .word_i(word), .cs_ni(cs_n), .sclk_i(sclk_in),
    .sclk_o(sclk_o), .sclk_oe_o(sclk_oe), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rdy_no(rdy_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] enc(input logic [W-1:0] w, input logic bip);
    return bip ? w : (w ^ 24'h800000);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] w, input logic bip);
    word = w; bipolar = bip; word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  // master: capture n bits at sclk_o high phases
  task automatic m_bits(input int n, output logic [W-1:0] got, output int first_dly, output bit gap_ok);
    int gap;
    got = '0; first_dly = 0; gap_ok = 1;
    for (int i = 0; i < n; i++) begin
      gap = 0;
      do begin
        @(negedge clk); gap++;
      end while (!sclk_o && gap < 400);
      if (i == 0) first_dly = gap;
      else if (gap != 2) gap_ok = 0;
      got = {got[W-2:0], sdo};
    end
  endtask

  // slave: drive external sclk, sample before each rise
  task automatic s_bits(input int n, input int gap, output logic [W-1:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sclk_in = 1'b0;
      cyc(6 + ((i % 2) ? gap : 0));
      got = {got[W-2:0], sdo};
      sclk_in = 1'b1;
      cyc(6);
    end
  endtask

  task automatic t_reset;
    cyc(1);
    chk(rdy_n === 1'b1, "R5 reset rdy", rdy_n, 1);
    chk(sdo_oe === 1'b0 && sclk_oe === 1'b0, "R6 reset oe", {sdo_oe, sclk_oe}, 0);
    chk(sclk_o === 1'b0, "R1 reset sclk", sclk_o, 0);
  endtask

  task automatic t_master_basic;
    logic [W-1:0] got; int d; bit g;
    load(24'h123456, 1'b1);
    chk(rdy_n === 1'b0, "R5 rdy after load", rdy_n, 0);
    cyc(5);
    chk(sclk_o === 1'b0 && sdo_oe === 1'b0, "R6 idle with cs high", {sclk_o, sdo_oe}, 0);
    cs_n = 1'b0;
    m_bits(W, got, d, g);
    chk(got === 24'h123456, "R3 master data", got, 24'h123456);
    chk(d >= START_DLY, "R2 start delay", d, START_DLY);
    chk(g, "R1 one-cycle phases", g, 1);
    chk(sclk_oe === 1'b1 && sdo_oe === 1'b1, "R6 enables in read", {sclk_oe, sdo_oe}, 2'b11);
    cyc(1);
    chk(rdy_n === 1'b1, "R5 rdy after last bit", rdy_n, 1);
    cyc(4);
    chk(sclk_o === 1'b0, "R1 sclk idle low", sclk_o, 0);
    cs_n = 1'b1; cyc(4);
  endtask

  task automatic t_coding;
    logic [W-1:0] got; int d; bit g;
    logic [W-1:0] vals [3] = '{24'h800000, 24'h7FFFFF, 24'h000001};
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 3; k++) begin
        load(vals[k], b[0]);
        cs_n = 1'b0;
        m_bits(W, got, d, g);
        chk(got === enc(vals[k], b[0]), "R7 coding", got, enc(vals[k], b[0]));
        cs_n = 1'b1; cyc(4);
      end
  endtask

  task automatic t_shadow;
    logic [W-1:0] a, b; int d; bit g;
    load(24'hA5A5A5, 1'b1);
    cs_n = 1'b0;
    m_bits(10, a, d, g);
    load(24'h0F0F0F, 1'b0);
    m_bits(W - 10, b, d, g);
    a = (a << (W - 10)) | b;
    chk(a === 24'hA5A5A5, "R8 first word intact", a, 24'hA5A5A5);
    cyc(1);
    chk(rdy_n === 1'b0, "R8 rdy held for shadow", rdy_n, 0);
    m_bits(W, b, d, g);
    chk(b === enc(24'h0F0F0F, 1'b0), "R8 shadow word", b, enc(24'h0F0F0F, 1'b0));
    cs_n = 1'b1; cyc(4);
  endtask

  task automatic t_replace;
    logic [W-1:0] got; int d; bit g;
    load(24'h111111, 1'b1);
    cyc(2);
    load(24'h2468AC, 1'b1);
    cs_n = 1'b0;
    m_bits(W, got, d, g);
    chk(got === 24'h2468AC, "R10 pending replaced", got, 24'h2468AC);
    cs_n = 1'b1; cyc(4);
  endtask

  task automatic t_abort;
    logic [W-1:0] got; int d; bit g;
    load(24'hC3C3C3, 1'b1);
    cs_n = 1'b0;
    m_bits(5, got, d, g);
    cs_n = 1'b1; cyc(6);
    chk(sclk_o === 1'b0 && sdo_oe === 1'b0 && sclk_oe === 1'b0, "R9 stopped", {sclk_o, sdo_oe, sclk_oe}, 0);
    chk(rdy_n === 1'b0, "R9 rdy kept", rdy_n, 0);
    cs_n = 1'b0;
    m_bits(W, got, d, g);
    chk(got === 24'hC3C3C3, "R9 restart from MSB", got, 24'hC3C3C3);
    cs_n = 1'b1; cyc(4);
  endtask

  task automatic t_slave(input int gap, input logic [W-1:0] w);
    logic [W-1:0] got;
    mode_slave = 1'b1;
    load(w, 1'b1);
    cs_n = 1'b0; sclk_in = 1'b0;
    cyc(3);
    chk(sdo_oe === 1'b1 && sclk_oe === 1'b0, "R6 slave enables", {sdo_oe, sclk_oe}, 2'b10);
    s_bits(W, gap, got);
    chk(got === w, "R4 slave data", got, w);
    cyc(6);
    chk(rdy_n === 1'b0, "R5 rdy before final fall", rdy_n, 0);
    sclk_in = 1'b0; cyc(6);
    chk(rdy_n === 1'b1, "R5 rdy after final fall", rdy_n, 1);
    cs_n = 1'b1; cyc(4);
    chk(sdo_oe === 1'b0, "R6 slave release", sdo_oe, 0);
    mode_slave = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    t_reset();
    t_master_basic();
    t_coding();
    t_shadow();
    t_replace();
    t_abort();
    t_slave(0, 24'h9ABCDE);
    t_slave(11, 24'h35796B);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule